// File: doc/BRIEF.md
# Dual-Lane 160-Bit Hash Compression Core

This block runs one call of the RIPEMD-160 compression function. It takes a 160-bit chaining value made of five 32-bit words and a 512-bit message block made of sixteen 32-bit words, and returns the next chaining value. The message words must already be assembled as little-endian 32-bit values. Padding, byte gathering and length encoding belong to the caller.

Two lanes of five working words each start from the same chaining value. Each lane makes 80 steps, and the two lanes advance together at one step per clock. The lanes use different message word orders, boolean functions, round constants and rotation amounts. After the last step, one extra cycle adds both lanes and the old chaining value crosswise to form the result. The core is then presented with `done` for one cycle. A caller hashing a long message feeds each new block with the previous `state_out` as `state_in`.

Top module: `dlh_compress`

## Requirements
- R1: During and right after reset, `done` is 0 and `state_out` is all zeros.
- R2: A `start` sampled high while the core is idle is accepted. `done` then goes high for exactly one cycle, 81 clock edges after the accepting edge (80 step cycles plus one combine cycle). `state_out` takes the new value on that same edge.
- R3: A `start` sampled while steps or the combine cycle are in progress is ignored. The run in progress and its result are unchanged.
- R4: `state_in` and `block_in` are captured on the accepting edge, and later changes have no effect on that run. Word i occupies bits [32i+31:32i] of `state_in`, `block_in` and `state_out`.
- R5: Each step with working words (A,B,C,D,E) produces the new values (E, rotl(A+f(B,C,D)+X+K, s)+E, B, rotl(C,10), D). All sums are modulo 2^32, and s lies between 5 and 15 as fixed per step.
- R6: Step n belongs to round r = n/16. The five functions are F0=x^y^z, F1=z^(x&(y^z)), F2=(x|~y)^z, F3=y^(z&(x^y)) and F4=x^(y|~z). The left lane uses Fr and the right lane uses F(4-r). The left constants are 0, 5A827999, 6ED9EBA1, 8F1BBCDC and A953FD4E. The right constants are 50A28BE6, 5C4DD124, 6D703EF3, 7A6D76E9 and 0.
- R7: Position j of round r reads message word P^r(j) in the left lane and P^r((9j+5) mod 16) in the right lane. P maps 0..15 to 7,4,13,1,10,6,15,3,12,0,9,5,2,14,11,8.
- R8: With L and R the final lane words and h the captured chaining words, the new words are h1+Lc+Rd, h2+Ld+Re, h3+Le+Ra, h4+La+Rb and h0+Lb+Rc, in order word0 to word4.
- R9: `state_out` changes only on the edge that raises `done`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to compress one block (honoured only when idle) |
| state_in | input | 160 | Chaining value in, word i at bits [32i+31:32i] |
| block_in | input | 512 | Message block, word i at bits [32i+31:32i] |
| done | output | 1 | One-cycle pulse when the result is ready |
| state_out | output | 160 | New chaining value, word i at bits [32i+31:32i] |

## Verification
The only result the core produces is due 81 edges after the accepting edge. At that edge `done` and `state_out` change together. Every other `start` only matters through the result it must not disturb. The bench keeps a behavioural timing model that accepts `start` only when idle, counts 81 edges and then raises an expected `done` carrying an independently computed digest. It samples `done` and `state_out` on every falling edge and compares them against that model. Directed checks add a known-answer block, a latency count, `start` pulses during the step and combine cycles, input changes during a run, and the hold of `state_out` between results.

// File: rtl/dlh_pkg.sv
package dlh_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 5;
  localparam int BLK_WORDS = 16;
  localparam int ROUNDS    = 5;
  localparam int RND_STEPS = 16;
  localparam int STEPS     = ROUNDS * RND_STEPS;
  localparam int CNT_W     = $clog2(STEPS);
  localparam int STATE_W   = WORD_W * NUM_WORDS;
  localparam int BLOCK_W   = WORD_W * BLK_WORDS;
  localparam int CROT      = 10;

  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } lane_t;

  function automatic word_t rotl(word_t x, int unsigned s);
    return (x << s) | (x >> (WORD_W - s));
  endfunction

  function automatic word_t bool_fn(logic [2:0] sel, word_t x, word_t y, word_t z);
    case (sel)
      3'd0:    return x ^ y ^ z;
      3'd1:    return z ^ (x & (y ^ z));
      3'd2:    return (x | ~y) ^ z;
      3'd3:    return y ^ (z & (x ^ y));
      default: return x ^ (y | ~z);
    endcase
  endfunction

  function automatic word_t round_const(logic right, logic [2:0] r);
    case ({right, r})
      4'b0_001: return 32'h5A827999;
      4'b0_010: return 32'h6ED9EBA1;
      4'b0_011: return 32'h8F1BBCDC;
      4'b0_100: return 32'hA953FD4E;
      4'b1_000: return 32'h50A28BE6;
      4'b1_001: return 32'h5C4DD124;
      4'b1_010: return 32'h6D703EF3;
      4'b1_011: return 32'h7A6D76E9;
      default:  return 32'h00000000;
    endcase
  endfunction

  // One application of the round-to-round word permutation.
  function automatic logic [3:0] perm_step(logic [3:0] i);
    case (i)
      4'd0: return 4'd7;   4'd1: return 4'd4;   4'd2: return 4'd13;  4'd3: return 4'd1;
      4'd4: return 4'd10;  4'd5: return 4'd6;   4'd6: return 4'd15;  4'd7: return 4'd3;
      4'd8: return 4'd12;  4'd9: return 4'd0;   4'd10: return 4'd9;  4'd11: return 4'd5;
      4'd12: return 4'd2;  4'd13: return 4'd14; 4'd14: return 4'd11; default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] msg_index(logic right, logic [2:0] r, logic [3:0] p);
    logic [3:0] idx;
    idx = right ? (p * 4'd9 + 4'd5) : p;
    for (int k = 0; k < ROUNDS - 1; k++)
      if (k < int'(r)) idx = perm_step(idx);
    return idx;
  endfunction

  // Rotation amounts of one round, position 0 in the top nibble.
  function automatic logic [63:0] shift_row(logic right, logic [2:0] r);
    case ({right, r})
      4'b0_000: return 64'hBEFC5879BDEF6798;
      4'b0_001: return 64'h768DB97F7CF9B7DC;
      4'b0_010: return 64'hBD67E9DFE8D65C75;
      4'b0_011: return 64'hBCEFEF989E56865C;
      4'b0_100: return 64'h9F5B68DC5CDEB856;
      4'b1_000: return 64'h899BDFF5778BEEC6;
      4'b1_001: return 64'h9DF7C89B77C76FDB;
      4'b1_010: return 64'h97FB866ECD5EDD75;
      4'b1_011: return 64'hF58BEE6E69C9C5F8;
      default:  return 64'h85C9C5E68D65FDBB;
    endcase
  endfunction

  function automatic logic [3:0] shift_amt(logic right, logic [2:0] r, logic [3:0] p);
    logic [63:0] row;
    row = shift_row(right, r) >> (4 * (15 - int'(p)));
    return row[3:0];
  endfunction

  function automatic lane_t lane_step(lane_t w, logic [2:0] fsel, word_t k, word_t x,
                                      logic [3:0] s);
    lane_t n;
    n.a = w.e;
    n.b = rotl(w.a + bool_fn(fsel, w.b, w.c, w.d) + x + k, int'(s)) + w.e;
    n.c = w.b;
    n.d = rotl(w.c, CROT);
    n.e = w.d;
    return n;
  endfunction

  function automatic lane_t lanes_merge(lane_t h, lane_t l, lane_t r);
    lane_t o;
    o.a = h.b + l.c + r.d;
    o.b = h.c + l.d + r.e;
    o.c = h.d + l.e + r.a;
    o.d = h.e + l.a + r.b;
    o.e = h.a + l.b + r.c;
    return o;
  endfunction
endpackage

// File: rtl/dlh_seq.sv
module dlh_seq import dlh_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             run,
  output logic             fin,
  output logic [CNT_W-1:0] cnt
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_t;
  seq_t st;

  assign accept = start && (st == S_IDLE);
  assign run    = (st == S_RUN);
  assign fin    = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st  <= S_RUN;
          cnt <= '0;
        end
        S_RUN: if (cnt == CNT_W'(STEPS - 1)) st <= S_FIN;
               else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlh_lane.sv
module dlh_lane import dlh_pkg::*; #(
  parameter bit RIGHT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  lane_t              init,
  input  logic [BLOCK_W-1:0] blk,
  input  logic [2:0]         rnd,
  input  logic [3:0]         pos,
  output lane_t              words
);
  logic [2:0] fsel;
  logic [3:0] idx;
  word_t      xw;
  lane_t      nxt;

  assign fsel = RIGHT ? (3'(ROUNDS - 1) - rnd) : rnd;
  assign idx  = msg_index(RIGHT, rnd, pos);
  assign xw   = blk[{idx, 5'd0} +: WORD_W];
  assign nxt  = lane_step(words, fsel, round_const(RIGHT, rnd), xw, shift_amt(RIGHT, rnd, pos));

  always_ff @(posedge clk) begin
    if (!rst_n)    words <= '0;
    else if (load) words <= init;
    else if (adv)  words <= nxt;
  end
endmodule

// File: rtl/dlh_compress.sv
module dlh_compress import dlh_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [STATE_W-1:0] state_in,
  input  logic [BLOCK_W-1:0] block_in,
  output logic               done,
  output logic [STATE_W-1:0] state_out
);
  logic             seq_accept, seq_run, seq_fin;
  logic [CNT_W-1:0] seq_cnt;
  lane_t            chain_in, chain_q, lane_l, lane_r, merged;
  logic [BLOCK_W-1:0] blk_q;

  // Word 0 sits in the low bits; field a of lane_t holds word 0.
  assign chain_in = '{a: state_in[0 +: WORD_W],        b: state_in[WORD_W +: WORD_W],
                      c: state_in[2*WORD_W +: WORD_W], d: state_in[3*WORD_W +: WORD_W],
                      e: state_in[4*WORD_W +: WORD_W]};

  dlh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(seq_accept), .run(seq_run), .fin(seq_fin), .cnt(seq_cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    lane_t w;
    dlh_lane #(.RIGHT(g == 1)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(seq_accept), .adv(seq_run),
      .init(chain_in), .blk(blk_q),
      .rnd(seq_cnt[CNT_W-1:4]), .pos(seq_cnt[3:0]), .words(w)
    );
  end
  assign lane_l = g_lane[0].w;
  assign lane_r = g_lane[1].w;
  assign merged = lanes_merge(chain_q, lane_l, lane_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q   <= '0;
      blk_q     <= '0;
      state_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= seq_fin;
      if (seq_accept) begin
        chain_q <= chain_in;
        blk_q   <= block_in;
      end
      if (seq_fin) state_out <= {merged.e, merged.d, merged.c, merged.b, merged.a};
    end
  end
endmodule

// File: rtl/dlh_compress_chk.sv
module dlh_compress_chk import dlh_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic [STATE_W-1:0] state_out,
  input logic               accept,
  input logic               run,
  input logic               fin,
  input logic [CNT_W-1:0]   cnt
);
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (run && cnt == '0));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_fin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fin));
  assert_run_unbroken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != CNT_W'(STEPS - 1)) |=> (run && cnt == $past(cnt) + 1'b1));
  assert_last_step_to_fin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == CNT_W'(STEPS - 1)) |=> fin);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(state_out));
endmodule

bind dlh_compress dlh_compress_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .state_out(state_out),
  .accept(seq_accept), .run(seq_run), .fin(seq_fin), .cnt(seq_cnt)
);

// File: tb/dlh_compress_tb.sv
`timescale 1ns/1ps
module dlh_compress_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [159:0] st_in = '0;
  logic [511:0] blk_in = '0;
  logic         done;
  logic [159:0] st_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dlh_compress u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(st_in),
    .block_in(blk_in), .done(done), .state_out(st_out)
  );

  // ---------------- reference digest, role-rotating formulation -------------
  int        perm [16] = '{7, 4, 13, 1, 10, 6, 15, 3, 12, 0, 9, 5, 2, 14, 11, 8};
  int        widx [2][5][16];
  string     sh [2][5];
  bit [31:0] kc [2][5];

  initial begin
    sh[0] = '{"BEFC5879BDEF6798", "768DB97F7CF9B7DC", "BD67E9DFE8D65C75",
              "BCEFEF989E56865C", "9F5B68DC5CDEB856"};
    sh[1] = '{"899BDFF5778BEEC6", "9DF7C89B77C76FDB", "97FB866ECD5EDD75",
              "F58BEE6E69C9C5F8", "85C9C5E68D65FDBB"};
    kc[0] = '{32'h0, 32'h5A827999, 32'h6ED9EBA1, 32'h8F1BBCDC, 32'hA953FD4E};
    kc[1] = '{32'h50A28BE6, 32'h5C4DD124, 32'h6D703EF3, 32'h7A6D76E9, 32'h0};
    for (int j = 0; j < 16; j++) begin
      widx[0][0][j] = j;
      widx[1][0][j] = (9 * j + 5) % 16;
    end
    for (int ln = 0; ln < 2; ln++)
      for (int r = 1; r < 5; r++)
        for (int j = 0; j < 16; j++) widx[ln][r][j] = perm[widx[ln][r-1][j]];
  end

  function automatic bit [31:0] rl(bit [31:0] x, int s);
    bit [63:0] d;
    d = {x, x} << s;
    return d[63:32];
  endfunction

  function automatic bit [31:0] bfn(int n, bit [31:0] x, bit [31:0] y, bit [31:0] z);
    case (n)
      0: return x ^ y ^ z;
      1: return (x & y) | (~x & z);
      2: return (x | ~y) ^ z;
      3: return (x & z) | (y & ~z);
      default: return x ^ (y | ~z);
    endcase
  endfunction

  function automatic int hexv(byte ch);
    return (ch >= 8'd65) ? int'(ch) - 55 : int'(ch) - 48;
  endfunction

  function automatic bit [159:0] ref_compress(bit [159:0] h, bit [511:0] m);
    bit [31:0] hw [5];
    bit [31:0] w [2][5];
    bit [31:0] nw [5];
    for (int i = 0; i < 5; i++) begin
      hw[i] = h[32*i +: 32];
      w[0][i] = hw[i];
      w[1][i] = hw[i];
    end
    for (int ln = 0; ln < 2; ln++)
      for (int n = 0; n < 80; n++) begin
        int r, j, ia, ib, ic, id, ie, fn;
        r = n / 16; j = n % 16;
        ia = (5 - n % 5) % 5; ib = (ia + 1) % 5; ic = (ia + 2) % 5;
        id = (ia + 3) % 5;    ie = (ia + 4) % 5;
        fn = (ln == 0) ? r : 4 - r;
        w[ln][ia] = rl(w[ln][ia] + bfn(fn, w[ln][ib], w[ln][ic], w[ln][id])
                       + m[32*widx[ln][r][j] +: 32] + kc[ln][r], hexv(sh[ln][r][j]))
                    + w[ln][ie];
        w[ln][ic] = rl(w[ln][ic], 10);
      end
    nw[0] = hw[1] + w[0][2] + w[1][3];
    nw[1] = hw[2] + w[0][3] + w[1][4];
    nw[2] = hw[3] + w[0][4] + w[1][0];
    nw[3] = hw[4] + w[0][0] + w[1][1];
    nw[4] = hw[0] + w[0][1] + w[1][2];
    return {nw[4], nw[3], nw[2], nw[1], nw[0]};
  endfunction

  // ---------------- cycle timing model ----------------
  logic         m_busy = 1'b0;
  int           m_cnt = 0;
  logic         m_done = 1'b0;
  logic [159:0] m_out = '0;
  logic [159:0] m_exp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_cnt <= 0; m_done <= 1'b0; m_out <= '0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 80) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_out <= m_exp;
        end else m_cnt <= m_cnt + 1;
      end else if (start) begin
        m_busy <= 1'b1; m_cnt <= 0; m_exp <= ref_compress(st_in, blk_in);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === m_done, "R2 R3", "done vs model", {159'd0, done}, {159'd0, m_done});
      chk(st_out === m_out, "R5 R6 R7 R8 R9", "state_out vs model", st_out, m_out);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [511:0] rnd_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 300);
  endtask

  task automatic run_one(logic [159:0] h, logic [511:0] m, output int cyc);
    @(negedge clk);
    st_in = h; blk_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  localparam logic [159:0] IV = {32'hC3D2E1F0, 32'h10325476, 32'h98BADCFE,
                                 32'hEFCDAB89, 32'h67452301};

  initial begin
    int cyc;
    logic [511:0] kat;
    logic [159:0] ha, hold_v;
    logic [511:0] ba;

    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1", "done in reset", {159'd0, done}, 160'd0);
    chk(st_out === '0, "R1", "state_out in reset", st_out, 160'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_out === '0 && done === 1'b0, "R1", "after reset release", st_out, 160'd0);

    // known answer: one-block message "abc"
    kat = '0;
    kat[31:0] = 32'h80636261;
    kat[14*32 +: 32] = 32'h00000018;
    run_one(IV, kat, cyc);
    chk(cyc == 82, "R2", "latency in falling edges", 160'(cyc), 160'd82);
    chk(st_out === {32'hFC0B5AF1, 32'h87B0C698, 32'h8E4A049B, 32'h7A985DE0, 32'hF708B28E},
        "R5 R6 R7 R8", "known-answer digest", st_out,
        {32'hFC0B5AF1, 32'h87B0C698, 32'h8E4A049B, 32'h7A985DE0, 32'hF708B28E});
    @(negedge clk);
    chk(done === 1'b0, "R2", "done one cycle wide", {159'd0, done}, 160'd0);

    // R9: output held while idle
    hold_v = st_out;
    repeat (20) @(negedge clk);
    chk(st_out === hold_v, "R9", "state_out held while idle", st_out, hold_v);

    // corner patterns
    run_one('0, '0, cyc);
    chk(st_out === ref_compress('0, '0), "R5 R8", "all-zero inputs", st_out, ref_compress('0, '0));
    run_one('1, '1, cyc);
    chk(st_out === ref_compress('1, '1), "R5 R8", "all-one inputs", st_out, ref_compress('1, '1));

    // random blocks, chained
    for (int t = 0; t < 6; t++) begin
      logic [159:0] hp;
      logic [511:0] bp;
      hp = (t == 0) ? IV : st_out;
      bp = rnd_block();
      run_one(hp, bp, cyc);
      chk(st_out === ref_compress(hp, bp), "R6 R7", "random chained block", st_out,
          ref_compress(hp, bp));
    end

    // R3 and R4: start pulses and input changes while busy, incl. combine cycle
    ha = {$urandom, $urandom, $urandom, $urandom, $urandom};
    ba = rnd_block();
    @(negedge clk);
    st_in = ha; blk_in = ba; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      if (cyc == 10) begin start = 1'b1; st_in = ~ha; blk_in = rnd_block(); end
      if (cyc == 13) start = 1'b0;
      if (cyc == 40) blk_in = rnd_block();
      if (cyc == 81) start = 1'b1;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == 82, "R3", "latency with starts while busy", 160'(cyc), 160'd82);
    chk(st_out === ref_compress(ha, ba), "R3 R4", "result unaffected by busy inputs",
        st_out, ref_compress(ha, ba));
    repeat (90) @(negedge clk);
    chk(st_out === ref_compress(ha, ba), "R3", "start in combine cycle not accepted",
        st_out, ref_compress(ha, ba));

    // start held high: back-to-back runs checked by the model
    @(negedge clk);
    st_in = IV; blk_in = kat; start = 1'b1;
    repeat (170) @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    repeat (5) @(negedge clk);
    chk(st_out === ref_compress(IV, kat), "R2", "back-to-back result", st_out,
        ref_compress(IV, kat));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule